// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Generator

This block produces the timing for a master-mode PCM audio port: a serial bit clock and a frame-sync pulse. Two clock-enable inputs are offered as possible sources, one from the bus clock domain and one from a dedicated audio clock. A select bit picks one of them. The block counts ticks of the chosen enable in a half-period divider to toggle the bit clock. It then counts bit clocks to mark the first bit of every frame with a sync pulse.

Generation is gated by a serial-clock enable. In continuous mode the clock runs whenever it is enabled. In gated mode it also needs the busy indication from the data path. Divider settings are held in shadow copies. The frame counter takes new settings only at the rising bit-clock edge that opens a frame, so a running frame always finishes with a whole number of full-length bit periods.

The bit-clock divider is a small state machine with three states. OFF means not running, with everything cleared. LOW is the low half of a bit period and HIGH is the high half. Its transitions are:
- Start: OFF to LOW, when the run condition becomes true.
- Rise: LOW to HIGH, when the half-period count expires on a tick.
- Fall: HIGH to LOW, when the half-period count expires on a tick.
- Stop: any state to OFF, when the run condition drops.

Top module: `serclk_sync_gen`

## Requirements
- R1: One half period of `bclk` lasts `half_div`+1 ticks of the selected source enable, so a full bit period is 2*(`half_div`+1) ticks. After a start, `bclk` is low for the first half period.
- R2: A frame lasts `frame_div`+1 bit periods. `fsync` goes high at the rising `bclk` edge that opens a frame and stays high for exactly one bit period (with `frame_div`=0 it stays high). The first rise after a start opens a frame.
- R3: `src_sel`=1 selects `aud_tick` and `src_sel`=0 selects `bus_tick`. Ticks on the unselected input have no effect on any output.
- R4: While `sclk_en` is 0, `bclk`, `bclk_rise`, `bclk_fall` and `fsync` are low from the first edge on, and the internal counters are cleared. When `sclk_en` is raised again, timing restarts from the beginning as in R1.
- R5: With `cont_mode`=1 the clock runs whatever the level of `xfer_busy`. With `cont_mode`=0 it runs only while `xfer_busy`=1 and stops as in R4 when `xfer_busy` is 0.
- R6: `bclk_rise` (and likewise `bclk_fall`) is high for exactly the one cycle in which `bclk` first shows its new high (or low) level. The two strobes are never high together.
- R7: A change of `half_div` or `frame_div` while running takes effect at the next rising edge that opens a frame. The frame in progress completes with the old values.
- R8: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | Source select: 1 audio tick, 0 bus tick |
| bus_tick | input | 1 | Clock enable derived from the bus clock |
| aud_tick | input | 1 | Clock enable derived from the audio clock |
| half_div | input | DIV_W (9) | Bit-clock half-period divider |
| frame_div | input | FRM_W (9) | Bits per frame minus one |
| sclk_en | input | 1 | Serial clock enable |
| cont_mode | input | 1 | 1 continuous clock, 0 clock only while busy |
| xfer_busy | input | 1 | Transmit or receive active |
| bclk | output | 1 | Serial bit clock |
| bclk_rise | output | 1 | One-cycle strobe for a new high level of bclk |
| bclk_fall | output | 1 | One-cycle strobe for a new low level of bclk |
| fsync | output | 1 | Frame sync, one bit period at frame start |

## Verification
At the rising edge that opens a frame, three things happen in the same cycle. The divider takes its reloaded half-period value, the rise strobe fires, and the sync rises. This coincidence is provoked by changing both divider fields in the middle of a frame. The bench then judges every later cycle against a piecewise arithmetic model. That model keeps the old settings up to the computed tick of the next frame start and applies the new settings as a fresh start from that tick. The bench also lowers the run condition in the same cycle as pending ticks, and expects every output to go quiet on that edge.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
    typedef enum logic [1:0] {
        BC_OFF  = 2'd0,
        BC_LOW  = 2'd1,
        BC_HIGH = 2'd2
    } bclk_state_t;
endpackage

// File: rtl/serclk_gate.sv
module serclk_gate (
    input  logic src_sel,
    input  logic bus_tick,
    input  logic aud_tick,
    input  logic sclk_en,
    input  logic cont_mode,
    input  logic xfer_busy,
    output logic run,
    output logic tick
);
    // Source enable mux and run qualification
    always_comb begin
        tick = src_sel ? aud_tick : bus_tick;
        run  = sclk_en && (cont_mode || xfer_busy);
    end
endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
    import serclk_pkg::*;
#(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] half_div,
    input  logic             reload,
    output logic             bclk,
    output logic             bclk_rise,
    output logic             bclk_fall,
    output logic             rise_evt
);
    bclk_state_t      state_q, state_d;
    logic [DIV_W-1:0] ph_q;
    logic [DIV_W-1:0] act_half_q;
    logic             expire;
    logic             fall_evt;

    always_comb begin
        expire   = tick && (ph_q == act_half_q);
        rise_evt = run && (state_q == BC_LOW)  && expire;
        fall_evt = run && (state_q == BC_HIGH) && expire;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = BC_OFF;
        end else begin
            unique case (state_q)
                BC_OFF:  state_d = BC_LOW;
                BC_LOW:  if (expire) state_d = BC_HIGH;
                BC_HIGH: if (expire) state_d = BC_LOW;
                default: state_d = BC_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BC_OFF;
        else        state_q <= state_d;
    end

    // Outputs and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk       <= 1'b0;
            bclk_rise  <= 1'b0;
            bclk_fall  <= 1'b0;
            ph_q       <= '0;
            act_half_q <= '0;
        end else begin
            bclk      <= (state_d == BC_HIGH);
            bclk_rise <= rise_evt;
            bclk_fall <= fall_evt;
            if (!run || state_q == BC_OFF) ph_q <= '0;
            else if (tick)                 ph_q <= expire ? '0 : ph_q + 1'b1;
            if (!run || state_q == BC_OFF || reload) act_half_q <= half_div;
        end
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != BC_OFF) |-> (ph_q <= act_half_q)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise && bclk_fall)); // R6
    AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise |-> (bclk && !$past(bclk))); // R6
    AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall |-> (!bclk && $past(bclk))); // R6
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!bclk && !bclk_rise && !bclk_fall)); // R4
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
    parameter int FRM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rise_evt,
    input  logic [FRM_W-1:0] frame_div,
    output logic             reload,
    output logic             fsync
);
    logic [FRM_W-1:0] bit_cnt_q;
    logic [FRM_W-1:0] act_frame_q;
    logic [FRM_W-1:0] limit;
    logic             frame_start;

    always_comb begin
        frame_start = rise_evt && (bit_cnt_q == '0);
        limit       = frame_start ? frame_div : act_frame_q;
        reload      = frame_start;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            act_frame_q <= '0;
            fsync       <= 1'b0;
        end else if (!run) begin
            bit_cnt_q   <= '0;
            act_frame_q <= frame_div;
            fsync       <= 1'b0;
        end else if (rise_evt) begin
            bit_cnt_q <= (bit_cnt_q == limit) ? '0 : bit_cnt_q + 1'b1;
            fsync     <= frame_start;
            if (frame_start) act_frame_q <= frame_div;
        end
    end

    AST_SYNC_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync != $past(fsync)) |-> ($past(rise_evt) || !$past(run))); // R2
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt_q != '0) |-> (bit_cnt_q <= act_frame_q)); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((bit_cnt_q == '0) && !fsync)); // R4
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_start) |=> $stable(act_frame_q)); // R7
endmodule

// File: rtl/serclk_sync_gen.sv
module serclk_sync_gen #(
    parameter int DIV_W = 9,
    parameter int FRM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic             bus_tick,
    input  logic             aud_tick,
    input  logic [DIV_W-1:0] half_div,
    input  logic [FRM_W-1:0] frame_div,
    input  logic             sclk_en,
    input  logic             cont_mode,
    input  logic             xfer_busy,
    output logic             bclk,
    output logic             bclk_rise,
    output logic             bclk_fall,
    output logic             fsync
);
    logic run;
    logic tick;
    logic rise_evt;
    logic reload;

    serclk_gate u_gate (
        .src_sel   (src_sel),
        .bus_tick  (bus_tick),
        .aud_tick  (aud_tick),
        .sclk_en   (sclk_en),
        .cont_mode (cont_mode),
        .xfer_busy (xfer_busy),
        .run       (run),
        .tick      (tick)
    );

    bclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .half_div  (half_div),
        .reload    (reload),
        .bclk      (bclk),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .rise_evt  (rise_evt)
    );

    frame_counter #(.FRM_W(FRM_W)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rise_evt  (rise_evt),
        .frame_div (frame_div),
        .reload    (reload),
        .fsync     (fsync)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!bclk && !fsync && !bclk_rise && !bclk_fall)); // R8
    AST_SYNC_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> bclk_rise); // R2
endmodule

// File: tb/serclk_sync_gen_test.sv
module serclk_sync_gen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_sel = 1'b0, bus_tick = 1'b0, aud_tick = 1'b0;
    logic [8:0] half_div = '0, frame_div = '0;
    logic       sclk_en = 1'b0, cont_mode = 1'b1, xfer_busy = 1'b0;
    logic       bclk, bclk_rise, bclk_fall, fsync;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit m_act = 0, m_tk = 0, m_chg = 0;
    int m_t = 0, m_h = 0, m_f = 0, m_hn = 0, m_fn = 0, m_t1 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serclk_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .bus_tick(bus_tick),
        .aud_tick(aud_tick), .half_div(half_div), .frame_div(frame_div),
        .sclk_en(sclk_en), .cont_mode(cont_mode), .xfer_busy(xfer_busy),
        .bclk(bclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .fsync(fsync)
    );

    // {bclk, rise, fall, fsync} after t selected ticks since start
    function automatic logic [3:0] ref_out(int t, bit tk, int h, int f);
        int  p;
        bit  at;
        p  = t / (h + 1);
        at = (t % (h + 1)) == 0;
        ref_out[3] = (p % 2) == 1;
        ref_out[2] = tk && at && ((p % 2) == 1);
        ref_out[1] = tk && at && (p > 0) && ((p % 2) == 0);
        ref_out[0] = (p >= 1) && ((((p - 1) / 2) % (f + 1)) == 0);
    endfunction

    task automatic chk(string req, string phase, logic got, logic exp_v, string what);
        n_chk++;
        if (got !== exp_v) begin
            n_fail++;
            if (n_fail < 30)
                $display("FAIL %s (%s) %s cyc=%0d got=%b exp=%b", req, phase, what, cyc, got, exp_v);
        end
    endtask

    task automatic step(string phase);
        logic [3:0] e;
        bit run_now, sel_tk;
        @(negedge clk);
        bus_tick = (cyc % 3) == 0;
        aud_tick = (cyc % 4) != 3;
        @(posedge clk);
        run_now = sclk_en && (cont_mode || xfer_busy);
        sel_tk  = src_sel ? aud_tick : bus_tick;
        if (!run_now) m_act = 0;
        else if (!m_act) begin m_act = 1; m_t = 0; m_tk = 0; end
        else begin m_tk = sel_tk; if (sel_tk) m_t++; end
        #1;
        if (!m_act) e = 4'b0000;
        else if (m_chg && m_t > m_t1) e = ref_out(m_t - m_t1 + m_hn + 1, m_tk, m_hn, m_fn);
        else e = ref_out(m_t, m_tk, m_h, m_f);
        chk("R1", phase, bclk,      e[3], "bclk");
        chk("R6", phase, bclk_rise, e[2], "bclk_rise");
        chk("R6", phase, bclk_fall, e[1], "bclk_fall");
        chk("R2", phase, fsync,     e[0], "fsync");
        cyc++;
    endtask

    task automatic run_steps(int n, string phase);
        for (int i = 0; i < n; i++) step(phase);
    endtask

    task automatic set_cfg(int h, int f);
        half_div = 9'(h); frame_div = 9'(f); m_h = h; m_f = f; m_chg = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R8: reset state, with the run condition already asserted
        set_cfg(1, 3); sclk_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            chk("R8", "reset", bclk | bclk_rise | bclk_fall | fsync, 1'b0, "outputs");
        end
        @(negedge clk); sclk_en = 1'b0; rst_n = 1'b1;
        run_steps(3, "R4");

        // R1 R2 R3 R6: sweep of source, half divider and frame length
        for (int s = 0; s < 2; s++)
            for (int h = 0; h < 4; h++)
                for (int f = 0; f < 4; f++) begin
                    src_sel = s[0]; set_cfg(h, f); sclk_en = 1'b1;
                    run_steps((3 * 2 * (h + 1) * (f + 1) + h + 2) * 3, "R3");
                    sclk_en = 1'b0;
                    run_steps(3, "R4");
                end

        // R5: gated mode follows busy, continuous mode ignores it
        src_sel = 1'b1; set_cfg(1, 2); cont_mode = 1'b0; xfer_busy = 1'b0; sclk_en = 1'b1;
        run_steps(20, "R5");
        xfer_busy = 1'b1; run_steps(37, "R5");
        xfer_busy = 1'b0; run_steps(10, "R5");
        xfer_busy = 1'b1; run_steps(25, "R5");
        cont_mode = 1'b1; xfer_busy = 1'b0; run_steps(40, "R5");
        sclk_en = 1'b0; run_steps(3, "R4");

        // R7: divider change mid-frame takes effect at the next frame start
        src_sel = 1'b1; set_cfg(1, 3); sclk_en = 1'b1;
        while (!(m_act && m_t >= 7)) step("R7");
        begin
            int per;
            per = 2 * (m_h + 1) * (m_f + 1);
            m_t1 = (m_h + 1) + ((m_t - (m_h + 1)) / per + 1) * per;
        end
        m_hn = 2; m_fn = 1; half_div = 9'd2; frame_div = 9'd1; m_chg = 1;
        run_steps(120, "R7");
        sclk_en = 1'b0; run_steps(3, "R4");
        m_chg = 0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule